// File: doc/BRIEF.md
# Receive Destination Address Filter with Multicast Hash

This block sits in the receive path of an Ethernet MAC and decides, for every incoming frame, whether the frame is kept. It watches the first six bytes of the frame, which form the destination address, and runs a CRC-32 over them as they arrive. After the sixth byte it reports one accept-or-reject decision and holds it until the next frame begins.

There are three ways for a frame to pass. A programmable number of exact-match address slots can each be loaded with a station address, or with all ones to let broadcast through. A 64-bin hash table catches group addresses: the bin is chosen by a 6-bit field of the final, reordered CRC. A promiscuous bit passes everything. A small write-only configuration port sets the table words, the mode bits and the slot contents.

Top module: `mhf_rx_filter`

## Requirements
- R1: Configuration writes use `cfg_addr`. Addresses 0 to 3 load the four 16-bit hash words, lowest bins first. Address 4 is the control word, with bit0 = promiscuous, bit1 = hash enable, bit2 = slot 0 enable and bit3 = slot 1 enable. Slot s occupies addresses 8+4s (low), 9+4s (middle) and 10+4s (high). Bin n of the table is bit n%16 of hash word n/16.
- R2: The hash bin is computed as follows. Start from a CRC register of all ones. Feed the six address bytes in arrival order, each least-significant bit first, using the reflected polynomial 0xEDB88320. Reverse all 32 bits of the result, then swap its byte order. The bin index is bits 28:23 of that final value.
- R3: With hash enable set, a frame whose first address byte has bit0 = 1 (a group address) is accepted when its bin in the table is 1. An address whose first byte has bit0 = 0 is never accepted through the table. With every path disabled, every frame is rejected.
- R4: With hash enable clear, the table has no effect, even when all four words are 0xFFFF. With hash enable set and all four words 0xFFFF, every group address is accepted.
- R5: With the promiscuous bit set, every frame is accepted.
- R6: A slot holds address bytes b0..b5 (b0 arrives first) as low = {b1,b0}, middle = {b3,b2}, high = {b5,b4}. An enabled slot whose contents equal the frame's address accepts the frame. A slot loaded with all ones accepts broadcast.
- R7: A write to any word of a slot while that slot's enable bit is set is ignored, and the old address keeps matching.
- R8: Call the rising edge that samples the sixth byte edge E. `dec_vld` rises after the next rising edge following E, with `accept` valid at the same time. Both hold until the edge that samples the next `sof`, which clears them.
- R9: Bytes after the sixth byte of a frame do not change the decision. Bytes that arrive before the first `sof` after reset produce no decision.
- R10: After reset, `dec_vld` and `accept` are 0, and all table words, control bits and slots are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| sof | input | 1 | Marks the first byte of a frame (with byte_vld) |
| byte_vld | input | 1 | Receive byte valid |
| byte_data | input | 8 | Receive byte |
| dec_vld | output | 1 | Decision valid, held until next frame start |
| accept | output | 1 | Frame accepted (meaningful while dec_vld) |

## Verification
The bench targets the following corner cases, and the failure each would show:
- A single table bin set for a computed group address. A design that skips the bit reversal or the byte swap, or takes the wrong bit slice, would look up a different bin and reject that address.
- The same address with its group bit cleared. A design that ignores the group bit would accept it.
- A fully set table with hash enable off. A design that ignores the enable would accept it.
- Rewriting an enabled slot. A design that does not lock the slot would lose the old station address.
- Trailing bytes after the address. A counter that fails to saturate would fold those bytes into the CRC and flip the decision.
- The exact cycle at which `dec_vld` rises. A design with an off-by-one pipeline would show the decision too early or too late.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam int unsigned HASH_LSB   = 23;

  typedef struct packed {
    logic promisc;
    logic hash_en;
  } mode_t;

  // one byte of a reflected CRC, least significant data bit first
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[CRC_W-1:1]} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction
endpackage

// File: rtl/mhf_crc_acc.sv
module mhf_crc_acc
  import mhf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [7:0]       din,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, crc_d, base_w;

  always_comb begin
    base_w = restart ? '1 : crc_q;
    crc_d  = crc_q;
    if (step) crc_d = crc_step(base_w, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/mhf_cfg_regs.sv
module mhf_cfg_regs
  import mhf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned BIN_BITS  = 6,
  parameter int unsigned AW        = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      we,
  input  logic [AW-1:0]                             addr,
  input  logic [WORD_W-1:0]                         wdata,
  output logic [(1<<BIN_BITS)-1:0]                  table_o,
  output mode_t                                     mode_o,
  output logic [NUM_SLOTS-1:0]                      slot_en_o,
  output logic [NUM_SLOTS-1:0][8*ADDR_BYTES-1:0]    slot_addr_o
);
  localparam int unsigned NBINS      = 1 << BIN_BITS;
  localparam int unsigned NWORDS     = NBINS / WORD_W;
  localparam int unsigned SLOT_WORDS = (8 * ADDR_BYTES) / WORD_W;
  localparam int unsigned CTL_W      = 2 + NUM_SLOTS;
  localparam int unsigned CTRL_ADDR  = 4;
  localparam int unsigned SLOT_BASE  = 8;

  logic [NWORDS-1:0][WORD_W-1:0]                     tab_q, tab_d;
  logic [CTL_W-1:0]                                  ctl_q, ctl_d;
  logic [NUM_SLOTS-1:0][SLOT_WORDS-1:0][WORD_W-1:0]  slot_q, slot_d;

  always_comb begin
    tab_d  = tab_q;
    ctl_d  = ctl_q;
    slot_d = slot_q;
    if (we) begin
      for (int w = 0; w < NWORDS; w++)
        if (addr == AW'(w)) tab_d[w] = wdata;
      if (addr == AW'(CTRL_ADDR)) ctl_d = wdata[CTL_W-1:0];
      for (int s = 0; s < NUM_SLOTS; s++)
        for (int w = 0; w < SLOT_WORDS; w++)
          if (addr == AW'(SLOT_BASE + 4*s + w) && !ctl_q[2+s])
            slot_d[s][w] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tab_q  <= '0;
      ctl_q  <= '0;
      slot_q <= '0;
    end else begin
      tab_q  <= tab_d;
      ctl_q  <= ctl_d;
      slot_q <= slot_d;
    end
  end

  assign table_o        = tab_q;
  assign mode_o.promisc = ctl_q[0];
  assign mode_o.hash_en = ctl_q[1];
  assign slot_en_o      = ctl_q[CTL_W-1:2];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_out
    assign slot_addr_o[s] = slot_q[s];
  end
endmodule

// File: rtl/mhf_match.sv
module mhf_match
  import mhf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned BIN_BITS  = 6
) (
  input  logic [8*ADDR_BYTES-1:0]                 addr,
  input  logic [CRC_W-1:0]                        crc,
  input  logic [(1<<BIN_BITS)-1:0]                table_i,
  input  mode_t                                   mode,
  input  logic [NUM_SLOTS-1:0]                    slot_en,
  input  logic [NUM_SLOTS-1:0][8*ADDR_BYTES-1:0]  slot_addr,
  output logic                                    hit
);
  logic [CRC_W-1:0]    rev_w, fin_w;
  logic [BIN_BITS-1:0] idx_w;
  logic                hash_hit_w;
  logic [NUM_SLOTS-1:0] slot_hit_w;

  always_comb begin
    for (int i = 0; i < CRC_W; i++) rev_w[CRC_W-1-i] = crc[i];
    fin_w = {rev_w[7:0], rev_w[15:8], rev_w[23:16], rev_w[31:24]};
  end

  assign idx_w      = fin_w[HASH_LSB +: BIN_BITS];
  assign hash_hit_w = mode.hash_en & addr[0] & table_i[idx_w];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_cmp
    assign slot_hit_w[s] = slot_en[s] & (slot_addr[s] == addr);
  end

  assign hit = mode.promisc | hash_hit_w | (|slot_hit_w);
endmodule

// File: rtl/mhf_rx_filter.sv
module mhf_rx_filter
  import mhf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned BIN_BITS  = 6,
  parameter int unsigned CFG_AW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              sof,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  output logic              dec_vld,
  output logic              accept
);
  localparam int unsigned AW_BITS = 8 * ADDR_BYTES;
  localparam int unsigned CW      = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] FULL  = CW'(ADDR_BYTES);
  localparam logic [CW-1:0] LAST  = CW'(ADDR_BYTES - 1);

  logic [CW-1:0]      cnt_q, cnt_d, pos_w;
  logic [AW_BITS-1:0] addr_q, addr_d;
  logic               last_q, last_d;
  logic               dec_q, dec_d, acc_q, acc_d;
  logic               start_w, take_w, hit_w;
  logic [CRC_W-1:0]   crc_w;

  logic [(1<<BIN_BITS)-1:0]              table_w;
  mode_t                                 mode_w;
  logic [NUM_SLOTS-1:0]                  slot_en_w;
  logic [NUM_SLOTS-1:0][AW_BITS-1:0]     slot_addr_w;
  logic                                  promisc_w, hash_en_w;

  assign start_w = sof & byte_vld;
  assign take_w  = byte_vld & (start_w | (cnt_q < FULL));
  assign pos_w   = start_w ? '0 : cnt_q;

  mhf_cfg_regs #(
    .NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .BIN_BITS(BIN_BITS), .AW(CFG_AW)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .table_o(table_w), .mode_o(mode_w), .slot_en_o(slot_en_w),
    .slot_addr_o(slot_addr_w)
  );

  mhf_crc_acc i_crc (
    .clk(clk), .rst_n(rst_n), .restart(start_w), .step(take_w),
    .din(byte_data), .crc_o(crc_w)
  );

  mhf_match #(.NUM_SLOTS(NUM_SLOTS), .BIN_BITS(BIN_BITS)) i_match (
    .addr(addr_q), .crc(crc_w), .table_i(table_w), .mode(mode_w),
    .slot_en(slot_en_w), .slot_addr(slot_addr_w), .hit(hit_w)
  );

  assign promisc_w = mode_w.promisc;
  assign hash_en_w = mode_w.hash_en;

  always_comb begin
    cnt_d  = cnt_q;
    addr_d = addr_q;
    last_d = 1'b0;
    dec_d  = dec_q;
    acc_d  = acc_q;
    if (take_w) begin
      cnt_d  = pos_w + CW'(1);
      last_d = (pos_w == LAST);
      for (int b = 0; b < ADDR_BYTES; b++)
        if (pos_w == CW'(b)) addr_d[b*8 +: 8] = byte_data;
    end
    if (start_w) begin
      dec_d = 1'b0;
      acc_d = 1'b0;
    end else if (last_q) begin
      dec_d = 1'b1;
      acc_d = hit_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= FULL;
      addr_q <= '0;
      last_q <= 1'b0;
      dec_q  <= 1'b0;
      acc_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      last_q <= last_d;
      dec_q  <= dec_d;
      acc_q  <= acc_d;
    end
  end

  assign dec_vld = dec_q;
  assign accept  = acc_q;
endmodule

// File: rtl/mhf_rx_filter_chk.sv
module mhf_rx_filter_chk #(
  parameter int unsigned NUM_SLOTS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sof,
  input logic                 byte_vld,
  input logic                 dec_vld,
  input logic                 accept,
  input logic                 promisc,
  input logic                 hash_en,
  input logic [NUM_SLOTS-1:0] slot_en
);
  logic [2:0] n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                n_q <= 3'd6;
    else if (sof && byte_vld)  n_q <= 3'd1;
    else if (byte_vld && n_q < 3'd6) n_q <= n_q + 3'd1;
  end

  AST_CLEAR_ON_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && byte_vld) |=> !dec_vld); // R8

  AST_HOLD_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && !(sof && byte_vld)) |=> (dec_vld && $stable(accept))); // R8

  AST_DECIDE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !sof && n_q == 3'd5) ##1 !(sof && byte_vld) |=> dec_vld); // R8

  AST_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_vld) && $past(promisc)) |-> accept); // R5

  AST_NO_PATH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_vld) && !$past(promisc) && !$past(hash_en) && ($past(slot_en) == '0))
      |-> !accept); // R3

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> !accept); // R10
endmodule

bind mhf_rx_filter mhf_rx_filter_chk #(.NUM_SLOTS(NUM_SLOTS)) i_chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
  .dec_vld(dec_vld), .accept(accept), .promisc(promisc_w),
  .hash_en(hash_en_w), .slot_en(slot_en_w)
);

// File: tb/test_mhf_rx_filter.sv
`timescale 1ns/1ps
module test_mhf_rx_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        sof, byte_vld;
  logic [7:0]  byte_data;
  logic        dec_vld, accept;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [15:0] m_tab [4];
  logic [3:0]  m_ctl;
  logic [15:0] m_slot [2][3];

  always #5 clk = ~clk;

  mhf_rx_filter i_mhf_rx_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sof(sof), .byte_vld(byte_vld),
    .byte_data(byte_data), .dec_vld(dec_vld), .accept(accept)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] bin_of(input logic [47:0] da);
    logic [31:0] c, r, f;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      c = c ^ {24'h0, da[8*k +: 8]};
      for (int j = 0; j < 8; j++)
        c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    for (int i = 0; i < 32; i++) r[i] = c[31-i];
    f = {r[7:0], r[15:8], r[23:16], r[31:24]};
    return f[28:23];
  endfunction

  function automatic logic exp_accept(input logic [47:0] da);
    logic [5:0] b;
    logic       e;
    b = bin_of(da);
    e = m_ctl[0];
    if (m_ctl[1] && da[0] && m_tab[b[5:4]][b[3:0]]) e = 1'b1;
    for (int s = 0; s < 2; s++)
      if (m_ctl[2+s] && {m_slot[s][2], m_slot[s][1], m_slot[s][0]} == da) e = 1'b1;
    return e;
  endfunction

  task automatic cfg_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 4) m_tab[a[1:0]] = d;
    else if (a == 4) m_ctl = d[3:0];
    else if (a >= 8 && a[1:0] != 2'd3 && !m_ctl[2 + a[2]]) m_slot[a[2]][a[1:0]] = d;
  endtask

  task automatic load_slot(input int s, input logic [47:0] da);
    logic [15:0] c0;
    c0 = {12'h0, m_ctl};
    cfg_write(4'd4, c0 & ~(16'h4 << s));
    for (int w = 0; w < 3; w++) cfg_write(4'(8 + 4*s + w), da[16*w +: 16]);
    cfg_write(4'd4, c0);
  endtask

  task automatic run_frame(input logic [47:0] da, input int extra, input string req);
    logic e;
    e = exp_accept(da);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sof = (i == 0); byte_vld = 1'b1; byte_data = da[8*i +: 8];
      if (i == 1) chk("R8 clear at sof", dec_vld, 1'b0);
    end
    @(negedge clk);
    sof = 1'b0; byte_vld = 1'b0;
    chk("R8 not before second edge", dec_vld, 1'b0);
    @(negedge clk);
    chk("R8 valid", dec_vld, 1'b1);
    chk(req, accept, e);
    if (extra > 0) begin
      for (int k = 0; k < extra; k++) begin
        @(negedge clk);
        byte_vld = 1'b1; byte_data = 8'($urandom);
      end
      @(negedge clk);
      byte_vld = 1'b0;
      @(negedge clk);
      chk("R9 trailing bytes dec_vld", dec_vld, 1'b1);
      chk("R9 trailing bytes accept", accept, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] mc, da;
    logic [5:0]  b;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) m_tab[i] = '0;
    m_ctl = '0;
    for (int s = 0; s < 2; s++) for (int w = 0; w < 3; w++) m_slot[s][w] = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    sof = 1'b0; byte_vld = 1'b0; byte_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 dec_vld reset", dec_vld, 1'b0);
    chk("R10 accept reset", accept, 1'b0);

    // R9: bytes without a sof produce no decision
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); byte_vld = 1'b1; byte_data = 8'(i);
    end
    @(negedge clk); byte_vld = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 no sof no decision", dec_vld, 1'b0);

    // R10: reset config rejects all, even broadcast
    run_frame(48'hFFFF_FFFF_FFFF, 0, "R10 default config rejects");

    // R2 R3: single bin for a group address
    mc = 48'h3412_0000_5E01;
    b  = bin_of(mc);
    cfg_write({2'b00, b[5:4]}, 16'h1 << b[3:0]);
    cfg_write(4'd4, 16'h0002);
    run_frame(mc, 0, "R2 R3 hashed group accepted");
    run_frame({mc[47:1], 1'b0}, 0, "R3 individual address not hashed");
    cfg_write({2'b00, b[5:4]}, ~(16'h1 << b[3:0]));
    run_frame(mc, 0, "R2 R3 other bins reject");

    // R4: all ones table, enable off then on
    for (int w = 0; w < 4; w++) cfg_write(4'(w), 16'hFFFF);
    cfg_write(4'd4, 16'h0000);
    run_frame(mc, 0, "R4 hash disabled ignores table");
    cfg_write(4'd4, 16'h0002);
    run_frame(48'h0102_0304_0507, 0, "R4 all multicast");
    run_frame(48'h0102_0304_0506, 0, "R4 unicast still rejected");

    // R5 promiscuous
    cfg_write(4'd4, 16'h0001);
    run_frame(48'h0A0B_0C0D_0E10, 2, "R5 promiscuous");

    // R6 exact slots: station and broadcast
    for (int w = 0; w < 4; w++) cfg_write(4'(w), 16'h0000);
    cfg_write(4'd4, 16'h0000);
    da = 48'h0913_0043_0700;
    load_slot(0, da);
    load_slot(1, 48'hFFFF_FFFF_FFFF);
    cfg_write(4'd4, 16'h000C);
    run_frame(da, 3, "R6 station slot match");
    run_frame(48'hFFFF_FFFF_FFFF, 0, "R6 broadcast slot");
    run_frame(da ^ 48'h0100_0000_0000, 0, "R6 near miss rejected");

    // R7 locked slot write ignored
    cfg_write(4'd8, 16'h5555);
    run_frame(da, 0, "R7 old address still matches");
    run_frame({da[47:16], 16'h5555}, 0, "R7 new address not loaded");
    load_slot(0, {da[47:16], 16'h5555});
    run_frame({da[47:16], 16'h5555}, 0, "R7 rewrite after disable");

    // R1: random configuration and addresses
    for (int n = 0; n < 60; n++) begin
      for (int w = 0; w < 4; w++) cfg_write(4'(w), 16'($urandom));
      cfg_write(4'd4, 16'($urandom_range(0, 15)) & ((n % 5 == 0) ? 16'hF : 16'hE));
      if (n % 4 == 0) load_slot(n % 2, {32'($urandom), 16'($urandom)});
      case (n % 3)
        0: da = {m_slot[0][2], m_slot[0][1], m_slot[0][0]};
        1: da = {32'($urandom), 16'($urandom)} | 48'h1;
        default: da = {32'($urandom), 16'($urandom)};
      endcase
      run_frame(da, n % 3, "R1 random frame");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule